// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This block turns one 64-bit send command into a single 32-bit store into the register space of another core. The store can leave chosen bytes of the target word untouched. A four-bit keep field in the command selects those bytes. When the field is clear, the block writes the whole data word straight away. When any keep bit is set, the block first reads the current target word, merges the new bytes into it, and writes the merged word back.

Commands come in over a valid/ready handshake, and a side input gives the command type. A mailbox-type command picks one of eight mailbox words at a fixed base. An any-type command carries a raw 16-bit target address.

The block reaches the target through a simple request/grant master port. That port carries a read or write flag, the target core index, the address and the write data. Read data returns later with its own valid strobe. A command that names a core which does not exist ends with an error indication and makes no access at all. Every command finishes with a one-cycle completion pulse.

Top module: `mbox_rmw_writer`

## Requirements
- R1: After reset, `cmd_ready` is 1 and both `mem_req` and `done_valid` are 0.
- R2: The target core index is `cmd_data[25:16]` and is driven on `mem_core` for every access. An index of `NUM_CORES` or above makes no memory access and completes with `done_err`=1.
- R3: When the keep field `cmd_data[30:27]` is zero, no read is issued. Exactly one write of `cmd_data[63:32]` is made.
- R4: When the keep field is nonzero, one read of the target word comes first, then one write. For each byte i (bits 8i+7:8i, little-endian), the written byte is the old byte if `cmd_data[27+i]` is 1 and the new byte from `cmd_data[63:32]` otherwise.
- R5: With `cmd_kind`=0 (mailbox), the target address is `MBOX_BASE` + 0x20 + (`cmd_data` AND 0x1C).
- R6: With `cmd_kind`=1 (any), the target address is `cmd_data[15:0]`.
- R7: A command is accepted only when idle. `cmd_ready` is 0 from the cycle after acceptance until completion, so a command held on the input meanwhile is neither accepted nor acted on.
- R8: While `mem_req` is high and `mem_gnt` is low, the request type, address, core and write data stay stable.
- R9: `done_valid` pulses for exactly one cycle, on the cycle after the write grant (or after acceptance of an erroring command). `done_err` is 0 on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_kind | input | 1 | 0 = mailbox command, 1 = any-address command |
| cmd_data | input | 64 | Command word |
| mem_req | output | 1 | Access request to target space |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_core | output | CORE_W | Target core index |
| mem_addr | output | ADDR_W | Target word address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done_valid | output | 1 | Command finished (one cycle) |
| done_err | output | 1 | Finished command named a missing core |

## Verification
The first request appears in the cycle after the acceptance edge. A write follows one cycle after the granted read's data returns. `done_valid` rises one cycle after the write grant, or one cycle after acceptance for an erroring command. The bench samples every output on the falling edge. It records each granted access at the falling edge before its granting rising edge, then polls for the completion pulse and checks it is gone one cycle later. Grant and read-return latencies are randomised, so the checks rely only on these relative orderings and never on fixed absolute cycle numbers.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_WAIT  = 3'd2,
      ST_WRITE = 3'd3,
      ST_DONE  = 3'd4
   } rmw_state_e;

   localparam int CORE_LSB  = 16;
   localparam int KEEP_LSB  = 27;
   localparam int WORD_LSB  = 32;
   localparam int SLOT_LSB  = 2;
   localparam int SLOT_W    = 3;
   localparam int MAIL_OFS  = 32'h20;
   localparam int RAW_ADDR_W = 16;
endpackage

// File: rtl/mbox_cmd_decode.sv
module mbox_cmd_decode #(
   parameter int CMD_W     = 64,
   parameter int DATA_W    = 32,
   parameter int CORE_W    = 10,
   parameter int ADDR_W    = 16,
   parameter int NUM_CORES = 4,
   parameter int MBOX_BASE = 32'h1000,
   localparam int BYTES    = DATA_W / 8
) (
   input  logic [CMD_W-1:0]  cmd_data,
   input  logic              cmd_kind,
   output logic [CORE_W-1:0] core_id,
   output logic              core_ok,
   output logic [DATA_W-1:0] new_word,
   output logic [BYTES-1:0]  keep_mask,
   output logic [ADDR_W-1:0] tgt_addr
);
   import mbox_pkg::*;

   localparam logic [CORE_W:0]   CORE_LIMIT = (CORE_W+1)'(NUM_CORES);
   localparam logic [ADDR_W-1:0] MAIL_ROOT  = ADDR_W'(MBOX_BASE + MAIL_OFS);

   logic [ADDR_W-1:0] mail_addr;
   logic [ADDR_W-1:0] any_addr;
   logic              unused_bits;

   assign core_id   = cmd_data[CORE_LSB +: CORE_W];
   assign core_ok   = {1'b0, core_id} < CORE_LIMIT;
   assign new_word  = cmd_data[WORD_LSB +: DATA_W];
   assign keep_mask = cmd_data[KEEP_LSB +: BYTES];

   assign mail_addr = MAIL_ROOT +
                      {{(ADDR_W-SLOT_LSB-SLOT_W){1'b0}}, cmd_data[SLOT_LSB +: SLOT_W], {SLOT_LSB{1'b0}}};

   generate
      if (ADDR_W > RAW_ADDR_W) begin : g_wide_addr
         assign any_addr = {{(ADDR_W-RAW_ADDR_W){1'b0}}, cmd_data[RAW_ADDR_W-1:0]};
      end else begin : g_exact_addr
         assign any_addr = cmd_data[RAW_ADDR_W-1:0];
      end
   endgenerate

   assign tgt_addr    = cmd_kind ? any_addr : mail_addr;
   assign unused_bits = ^{cmd_data[31], cmd_data[26]};
endmodule

// File: rtl/mbox_byte_merge.sv
module mbox_byte_merge #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8
) (
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] new_word,
   input  logic [BYTES-1:0]  keep,
   output logic [DATA_W-1:0] merged
);
   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign merged[8*b +: 8] = keep[b] ? old_word[8*b +: 8] : new_word[8*b +: 8];
   end
endmodule

// File: rtl/mbox_rmw_fsm.sv
module mbox_rmw_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic core_ok,
   input  logic keep_any,
   input  logic mem_gnt,
   input  logic mem_rvalid,
   output logic cmd_ready,
   output logic accept,
   output logic rd_capture,
   output logic mem_req,
   output logic mem_we,
   output logic done_valid
);
   import mbox_pkg::*;

   rmw_state_e state, state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (cmd_valid) state_nx = !core_ok ? ST_DONE : (keep_any ? ST_READ : ST_WRITE);
         ST_READ:  if (mem_gnt) state_nx = ST_WAIT;
         ST_WAIT:  if (mem_rvalid) state_nx = ST_WRITE;
         ST_WRITE: if (mem_gnt) state_nx = ST_DONE;
         ST_DONE:  state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   assign cmd_ready  = (state == ST_IDLE);
   assign accept     = cmd_ready && cmd_valid;
   assign rd_capture = (state == ST_WAIT) && mem_rvalid;
   assign mem_req    = (state == ST_READ) || (state == ST_WRITE);
   assign mem_we     = (state == ST_WRITE);
   assign done_valid = (state == ST_DONE);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);
   assert_write_after_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_gnt |=> done_valid);
   assert_read_then_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we && mem_gnt |=> !mem_req && !done_valid);
endmodule

// File: rtl/mbox_rmw_writer.sv
module mbox_rmw_writer #(
   parameter int CMD_W     = 64,
   parameter int DATA_W    = 32,
   parameter int CORE_W    = 10,
   parameter int ADDR_W    = 16,
   parameter int NUM_CORES = 4,
   parameter int MBOX_BASE = 32'h1000,
   localparam int BYTES    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_kind,
   input  logic [CMD_W-1:0]  cmd_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [CORE_W-1:0] mem_core,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done_valid,
   output logic              done_err
);
   generate
      if (CMD_W != 64)                 begin : g_bad_cmd  $error("CMD_W must be 64"); end
      if (DATA_W != 32)                begin : g_bad_data $error("DATA_W must be 32"); end
      if (CORE_W != 10)                begin : g_bad_core $error("CORE_W must be 10"); end
      if (ADDR_W < 16)                 begin : g_bad_addr $error("ADDR_W must be at least 16"); end
      if (NUM_CORES < 1 || NUM_CORES > (1 << CORE_W))
                                       begin : g_bad_num  $error("NUM_CORES out of range"); end
   endgenerate

   logic [CORE_W-1:0] dec_core;
   logic              dec_ok;
   logic [DATA_W-1:0] dec_word;
   logic [BYTES-1:0]  dec_keep;
   logic [ADDR_W-1:0] dec_addr;
   logic              accept, rd_capture;
   logic [DATA_W-1:0] merged;

   logic [CORE_W-1:0] core_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BYTES-1:0]  keep_q;
   logic [DATA_W-1:0] word_q;
   logic              err_q;

   mbox_cmd_decode #(
      .CMD_W(CMD_W), .DATA_W(DATA_W), .CORE_W(CORE_W), .ADDR_W(ADDR_W),
      .NUM_CORES(NUM_CORES), .MBOX_BASE(MBOX_BASE)
   ) u_decode (
      .cmd_data(cmd_data), .cmd_kind(cmd_kind),
      .core_id(dec_core), .core_ok(dec_ok), .new_word(dec_word),
      .keep_mask(dec_keep), .tgt_addr(dec_addr)
   );

   mbox_rmw_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .core_ok(dec_ok),
      .keep_any(|dec_keep), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .cmd_ready(cmd_ready), .accept(accept), .rd_capture(rd_capture),
      .mem_req(mem_req), .mem_we(mem_we), .done_valid(done_valid)
   );

   mbox_byte_merge #(.DATA_W(DATA_W)) u_merge (
      .old_word(mem_rdata), .new_word(word_q), .keep(keep_q), .merged(merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         core_q <= '0;
         addr_q <= '0;
         keep_q <= '0;
         word_q <= '0;
         err_q  <= 1'b0;
      end else if (accept) begin
         core_q <= dec_core;
         addr_q <= dec_addr;
         keep_q <= dec_keep;
         word_q <= dec_word;
         err_q  <= !dec_ok;
      end else if (rd_capture) begin
         word_q <= merged;
      end
   end

   assign mem_core  = core_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = word_q;
   assign done_err  = done_valid && err_q;

   assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> !cmd_ready);
   assert_no_plain_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> keep_q != '0);
   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_we) && $stable(mem_addr)
                              && $stable(mem_core) && $stable(mem_wdata));
   assert_err_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !err_q);
endmodule

// File: tb/mbox_rmw_writer_bench.sv
module mbox_rmw_writer_bench;
   localparam int NUM_CORES = 4;
   localparam int MBOX_BASE = 32'h1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_kind = 1'b0;
   logic [63:0] cmd_data = '0;
   logic        mem_req, mem_we;
   logic [9:0]  mem_core;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_gnt = 1'b0;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done_valid, done_err;

   always #5 clk = ~clk;

   mbox_rmw_writer #(.NUM_CORES(NUM_CORES), .MBOX_BASE(MBOX_BASE)) u_mbox_rmw_writer (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_kind(cmd_kind), .cmd_data(cmd_data), .mem_req(mem_req), .mem_we(mem_we),
      .mem_core(mem_core), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .done_valid(done_valid), .done_err(done_err)
   );

   int checks = 0;
   int fails  = 0;
   int n_rd = 0, n_wr = 0, rd_cnt = 0;
   logic [15:0] wr_addr, rd_addr;
   logic [9:0]  wr_core, rd_core;
   logic [31:0] wr_data;

   function automatic logic [31:0] rmodel(logic [9:0] core, logic [15:0] addr);
      return 32'h5A3C_96E1 ^ {addr, 6'd0, core};
   endfunction

   function automatic logic [15:0] exp_addr(logic kind, logic [63:0] c);
      if (kind) return c[15:0];
      return 16'(MBOX_BASE + 32'h20) + {11'd0, c[4:2], 2'b00};
   endfunction

   function automatic logic [31:0] exp_merge(logic [31:0] old_w, logic [31:0] new_w, logic [3:0] keep);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) r[8*i +: 8] = keep[i] ? old_w[8*i +: 8] : new_w[8*i +: 8];
      return r;
   endfunction

   function automatic logic [63:0] mk_cmd(logic [31:0] d, logic [3:0] keep, logic [9:0] core, logic [15:0] lo);
      return {d, 1'($urandom), keep, 1'($urandom), core, lo};
   endfunction

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // target-space model: random grants, delayed read return
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_gnt = 1'b0; mem_rvalid = 1'b0; rd_cnt = 0;
      end else begin
         mem_rvalid = 1'b0;
         if (rd_cnt > 0) begin
            rd_cnt--;
            if (rd_cnt == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = rmodel(rd_core, rd_addr);
            end
         end
         mem_gnt = mem_req && ($urandom_range(0, 2) != 0);
         if (mem_req && mem_gnt) begin
            if (mem_we) begin
               n_wr++; wr_addr = mem_addr; wr_core = mem_core; wr_data = mem_wdata;
            end else begin
               n_rd++; rd_addr = mem_addr; rd_core = mem_core;
               rd_cnt = int'($urandom_range(1, 3));
            end
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   task automatic run_cmd(logic kind, logic [63:0] c, bit hold);
      bit seen = 0;
      logic [9:0]  core = c[25:16];
      logic [3:0]  keep = c[30:27];
      bit          bad  = (int'(core) >= NUM_CORES);
      logic [15:0] ea   = exp_addr(kind, c);
      n_rd = 0; n_wr = 0;
      @(negedge clk);
      cmd_kind = kind; cmd_data = c; cmd_valid = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b0, "R7 busy after accept", 64'(cmd_ready), 0);
      if (hold) begin
         cmd_kind = ~kind; cmd_data = c ^ 64'h0000_0001_0000_0F0C;
      end else cmd_valid = 1'b0;
      for (int t = 0; t < 60 && !seen; t++) begin
         if (done_valid) seen = 1;
         else @(negedge clk);
      end
      cmd_valid = 1'b0;
      chk(seen, "R9 completion seen", 64'(seen), 1);
      if (seen) begin
         chk(done_err == bad, "R2/R9 error flag", 64'(done_err), 64'(bad));
         if (bad) begin
            chk(n_rd == 0 && n_wr == 0, "R2 no access on bad core", 64'(n_rd + n_wr), 0);
         end else begin
            chk(n_rd == ((keep != 0) ? 1 : 0), "R3/R4 read count", 64'(n_rd), 64'(keep != 0));
            chk(n_wr == 1, "R7 single write", 64'(n_wr), 1);
            chk(wr_addr == ea, kind ? "R6 any address" : "R5 mailbox address", 64'(wr_addr), 64'(ea));
            chk(wr_core == core, "R2 core index", 64'(wr_core), 64'(core));
            if (keep != 0) begin
               chk(rd_addr == ea && rd_core == core, "R4 read target", {rd_core, rd_addr}, {core, ea});
               chk(wr_data == exp_merge(rmodel(core, ea), c[63:32], keep), "R4 merged data",
                   64'(wr_data), 64'(exp_merge(rmodel(core, ea), c[63:32], keep)));
            end else begin
               chk(wr_data == c[63:32], "R3 full word", 64'(wr_data), 64'(c[63:32]));
            end
         end
         @(negedge clk);
         chk(done_valid == 1'b0, "R9 one-cycle pulse", 64'(done_valid), 0);
         chk(cmd_ready == 1'b1, "R7 idle again", 64'(cmd_ready), 1);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(cmd_ready == 1'b1, "R1 ready in reset", 64'(cmd_ready), 1);
      chk(mem_req == 1'b0 && done_valid == 1'b0, "R1 quiet in reset", {mem_req, done_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1 && mem_req == 1'b0, "R1 after reset", {cmd_ready, mem_req}, 2);
      // directed corners
      run_cmd(1'b0, mk_cmd(32'hDEAD_BEEF, 4'h0, 10'd1, 16'h0014), 0);   // R3 R5
      run_cmd(1'b0, mk_cmd(32'h1122_3344, 4'hF, 10'd2, 16'h001C), 0);   // R4 all kept
      run_cmd(1'b1, mk_cmd(32'hCAFE_F00D, 4'b0101, 10'd3, 16'hABCD), 0); // R4 R6
      run_cmd(1'b1, mk_cmd(32'h0BAD_0BAD, 4'h3, 10'd4, 16'h1234), 0);   // R2 boundary
      run_cmd(1'b0, mk_cmd(32'h7777_7777, 4'h0, 10'd1023, 16'h0000), 0); // R2
      run_cmd(1'b1, mk_cmd(32'h89AB_CDEF, 4'b1000, 10'd0, 16'hFFFC), 1); // R7 held input
      run_cmd(1'b0, mk_cmd(32'h0F0F_0F0F, 4'b0110, 10'd3, 16'hFFFF), 1); // R7 R5
      for (int k = 0; k < 150; k++) begin
         logic [3:0] keep = ($urandom_range(0, 9) < 3) ? 4'h0 : 4'($urandom);
         logic [9:0] core = ($urandom_range(0, 9) == 0) ? 10'($urandom_range(NUM_CORES, 1023))
                                                        : 10'($urandom_range(0, NUM_CORES - 1));
         run_cmd(1'($urandom), mk_cmd($urandom, keep, core, 16'($urandom)), ($urandom_range(0, 4) == 0));
      end
      finish_run();
   end
endmodule